// File: doc/BRIEF.md
# Shared Divide and Root Mantissa Core

This block is an iterative radix-2 recurrence that produces one result bit per clock cycle in plain binary form. It serves five operations from one datapath: unsigned integer divide with remainder, mantissa divide, square root, reciprocal square root, and a fused quotient of one operand by the square root of the other. Every step tries setting the next result bit. It keeps the bit only if a running product built from the trial result stays at or below a left-hand bound chosen for the operation. Reciprocal square root uses a fixed scaled 1.0 as that bound. The fused mode puts the scaled square of operand A in its place and changes nothing else.

Floating-point mantissas are W-bit values with the most significant bit set, so they read as numbers in [1, 2). For these modes the recurrence runs two extra steps, and the block hands a guard bit, a round bit and a sticky bit to a later rounding stage. Exponents, special values and rounding happen outside the block. A start pulse captures the operation and both operands. Once the result is ready, a single-cycle valid pulse appears and the outputs hold their value until the next result.

Top module: `divroot_core`

## Requirements
- R1: Operation code 0 (codes 5, 6 and 7 also) performs unsigned integer division of opa by a nonzero opb. The result is floor(opa/opb) and the remainder is opa mod opb.
- R2: In integer division with opb equal to zero, the result is all ones and the remainder equals opa.
- R3: Code 1 divides two normalized mantissas. With Q = floor(opa·2^(W+1)/opb): result = Q>>2, guard = Q bit 1, round = Q bit 0, and remainder = opa·2^(W+1) − Q·opb.
- R4: Code 2 takes the square root of opb. Q is the largest value with Q² ≤ opb·2^(W+3). The result, guard and round come from Q as in R3, and remainder = opb·2^(W+3) − Q².
- R5: Code 3 takes the reciprocal square root of opb. Q is the largest value with Q²·opb ≤ 2^(3W+1). The fields come from Q as in R3, and the remainder is the difference of the two sides.
- R6: Code 4 computes opa divided by the square root of opb. Q is the largest value with Q²·opb ≤ opa²·2^(W+3). The fields come from Q as in R3, and the remainder is the difference of the two sides. With opa = 2^(W-1) it gives the same output as R5.
- R7: In codes 1 to 4, sticky is 1 exactly when the remainder is nonzero.
- R8: In integer division, guard, round and sticky are all 0.
- R9: When start is sampled, valid goes high W+3 clock edges later for codes 1 to 4 and W+1 edges later for integer division. It stays high for exactly one cycle.
- R10: A start pulse that arrives during a calculation is ignored. It does not change the running result or its timing.
- R11: Changes to op, opa or opb after the start cycle do not affect the running calculation.
- R12: While reset is active and just after it is released, valid, result, remainder, guard, round and sticky are all 0.
- R13: result, remainder, guard, round and sticky change only in the cycle in which valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Starts an operation when the core is idle |
| op | input | 3 | Operation code (see R1 to R6) |
| opa | input | W | Dividend or numerator operand |
| opb | input | W | Divisor or root operand |
| valid | output | 1 | One-cycle pulse when a result is ready |
| result | output | W | Quotient or root bits |
| remainder | output | 3W+4 | Difference between the bound and the final running product |
| res_guard | output | 1 | First bit below the result (codes 1 to 4) |
| res_round | output | 1 | Second bit below the result (codes 1 to 4) |
| res_sticky | output | 1 | Nonzero-remainder flag (codes 1 to 4) |

## Verification
The hardest case to reach from the ports is an exact result with sticky equal to 0. Examples are an exact mantissa quotient, a perfect-square root, and the reciprocal root of exactly 1.0. Random operands almost never produce one. The bench therefore runs the core at W = 6 and sweeps every normalized operand, and every operand pair for the two-operand modes, so that each exact case occurs and is checked against integer arithmetic. A separate directed run fires a second start pulse, and changes the operands, partway through a calculation.

// File: rtl/divroot_pkg.sv
package divroot_pkg;

  typedef enum logic [2:0] {
    OP_IDIV   = 3'd0,
    OP_FDIV   = 3'd1,
    OP_FSQRT  = 3'd2,
    OP_FRSQRT = 3'd3,
    OP_FASQRT = 3'd4
  } divroot_op_e;

  // Codes 1..4 are the mantissa modes with guard/round/sticky output.
  function automatic logic op_is_fp(input logic [2:0] code);
    return (code >= 3'd1) && (code <= 3'd4);
  endfunction

endpackage

// File: rtl/divroot_setup.sv
module divroot_setup
  import divroot_pkg::*;
#(
  parameter int W  = 16,
  parameter int PW = 3*W+4,
  parameter int KW = 5
) (
  input  logic [2:0]    op,
  input  logic [W-1:0]  opa,
  input  logic [W-1:0]  opb,
  output logic [PW-1:0] lhs,
  output logic [W-1:0]  fac,
  output logic          sq_mode,
  output logic          fp_mode,
  output logic [KW-1:0] k_top
);

  localparam logic [KW-1:0] K_INT  = KW'(W-1);
  localparam logic [KW-1:0] K_FP   = KW'(W+1);
  localparam logic [PW-1:0] ONE_SC = PW'(1) << (3*W+1);

  logic [PW-1:0] a_w;
  logic [PW-1:0] b_w;
  logic [PW-1:0] a_sq;

  assign a_w  = {{(PW-W){1'b0}}, opa};
  assign b_w  = {{(PW-W){1'b0}}, opb};
  assign a_sq = a_w * a_w;

  always_comb begin
    lhs     = a_w;
    fac     = opb;
    sq_mode = 1'b0;
    fp_mode = 1'b0;
    k_top   = K_INT;
    case (op)
      OP_FDIV: begin
        lhs     = a_w << (W+1);
        fp_mode = 1'b1;
        k_top   = K_FP;
      end
      OP_FSQRT: begin
        lhs     = b_w << (W+3);
        fac     = W'(1);
        sq_mode = 1'b1;
        fp_mode = 1'b1;
        k_top   = K_FP;
      end
      OP_FRSQRT: begin
        lhs     = ONE_SC;
        sq_mode = 1'b1;
        fp_mode = 1'b1;
        k_top   = K_FP;
      end
      OP_FASQRT: begin
        lhs     = a_sq << (W+3);
        sq_mode = 1'b1;
        fp_mode = 1'b1;
        k_top   = K_FP;
      end
      default: begin
        lhs = a_w;
      end
    endcase
  end

endmodule

// File: rtl/divroot_step.sv
module divroot_step #(
  parameter int W  = 16,
  parameter int PW = 3*W+4,
  parameter int QW = W+2,
  parameter int KW = 5
) (
  input  logic [KW-1:0] k,
  input  logic          sq_mode,
  input  logic [W-1:0]  fac,
  input  logic [PW-1:0] lhs,
  input  logic [PW-1:0] p_acc,
  input  logic [PW-1:0] s_acc,
  input  logic [QW-1:0] q_acc,
  output logic [PW-1:0] p_nxt,
  output logic [PW-1:0] s_nxt,
  output logic [QW-1:0] q_nxt
);

  localparam int XW = PW + 1;

  logic [XW-1:0] fac_x, p_x, s_x, lhs_x;
  logic [XW-1:0] lin_t, sq_t, p_try;
  logic [PW-1:0] fac_w, s_try;
  logic [KW:0]   k1, k2;
  logic          take;

  assign k1    = {1'b0, k} + 1'b1;
  assign k2    = {k, 1'b0};
  assign fac_x = {{(XW-W){1'b0}}, fac};
  assign fac_w = {{(PW-W){1'b0}}, fac};
  assign p_x   = {1'b0, p_acc};
  assign s_x   = {1'b0, s_acc};
  assign lhs_x = {1'b0, lhs};

  // Linear modes add fac*2^k; square modes add 2^(k+1)*q*fac + 4^k*fac.
  assign lin_t = fac_x << k;
  assign sq_t  = (s_x << k1) + (fac_x << k2);
  assign p_try = p_x + (sq_mode ? sq_t : lin_t);
  assign take  = (p_try <= lhs_x);
  assign s_try = s_acc + (fac_w << k);

  assign p_nxt = take ? p_try[PW-1:0] : p_acc;
  assign s_nxt = take ? s_try : s_acc;
  assign q_nxt = take ? (q_acc | (QW'(1) << k)) : q_acc;

endmodule

// File: rtl/divroot_seq.sv
module divroot_seq #(
  parameter int KW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [KW-1:0] k_top,
  output logic          busy,
  output logic [KW-1:0] k,
  output logic          accept,
  output logic          last
);

  logic          busy_q, busy_d;
  logic [KW-1:0] k_q, k_d;

  assign accept = start & ~busy_q;
  assign last   = busy_q & (k_q == '0);
  assign busy   = busy_q;
  assign k      = k_q;

  always_comb begin
    busy_d = busy_q;
    k_d    = k_q;
    if (accept) begin
      busy_d = 1'b1;
      k_d    = k_top;
    end else if (busy_q) begin
      if (last) begin
        busy_d = 1'b0;
      end else begin
        k_d = k_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      k_q    <= '0;
    end else begin
      busy_q <= busy_d;
      k_q    <= k_d;
    end
  end

endmodule

// File: rtl/divroot_core.sv
module divroot_core #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [2:0]     op,
  input  logic [W-1:0]   opa,
  input  logic [W-1:0]   opb,
  output logic           valid,
  output logic [W-1:0]   result,
  output logic [3*W+3:0] remainder,
  output logic           res_guard,
  output logic           res_round,
  output logic           res_sticky
);

  localparam int QW = W + 2;
  localparam int PW = 3*W + 4;
  localparam int KW = $clog2(QW);

  // Reset synchronizer: asserts at once, releases on the clock.
  logic [1:0] rst_pipe;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  // Operation setup
  logic [PW-1:0] lhs_d;
  logic [W-1:0]  fac_d;
  logic          sq_d, fp_d;
  logic [KW-1:0] k_top;

  divroot_setup #(.W(W), .PW(PW), .KW(KW)) i_setup (
    .op      (op),
    .opa     (opa),
    .opb     (opb),
    .lhs     (lhs_d),
    .fac     (fac_d),
    .sq_mode (sq_d),
    .fp_mode (fp_d),
    .k_top   (k_top)
  );

  // Step sequencing
  logic          busy, accept, last;
  logic [KW-1:0] k;

  divroot_seq #(.KW(KW)) i_seq (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .start  (start),
    .k_top  (k_top),
    .busy   (busy),
    .k      (k),
    .accept (accept),
    .last   (last)
  );

  // Captured operation state
  logic [PW-1:0] lhs_q;
  logic [W-1:0]  fac_q;
  logic          sq_q, fp_q;
  logic [PW-1:0] p_q, s_q;
  logic [QW-1:0] q_q;

  logic [PW-1:0] p_nxt, s_nxt;
  logic [QW-1:0] q_nxt;

  divroot_step #(.W(W), .PW(PW), .QW(QW), .KW(KW)) i_step (
    .k       (k),
    .sq_mode (sq_q),
    .fac     (fac_q),
    .lhs     (lhs_q),
    .p_acc   (p_q),
    .s_acc   (s_q),
    .q_acc   (q_q),
    .p_nxt   (p_nxt),
    .s_nxt   (s_nxt),
    .q_nxt   (q_nxt)
  );

  // Next-state logic
  logic          acc_en;
  logic [PW-1:0] p_d, s_d;
  logic [QW-1:0] q_d;
  logic [PW-1:0] rem_d;
  logic [W-1:0]  res_d;
  logic          g_d, r_d, st_d;

  always_comb begin
    acc_en = accept | busy;
    p_d    = accept ? '0 : p_nxt;
    s_d    = accept ? '0 : s_nxt;
    q_d    = accept ? '0 : q_nxt;
    rem_d  = lhs_q - p_nxt;
    res_d  = fp_q ? q_nxt[QW-1:2] : q_nxt[W-1:0];
    g_d    = fp_q & q_nxt[1];
    r_d    = fp_q & q_nxt[0];
    st_d   = fp_q & (|rem_d);
  end

  // Registers
  logic           valid_q;
  logic [W-1:0]   result_q;
  logic [PW-1:0]  rem_q;
  logic           g_q, r_q, st_q;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      lhs_q    <= '0;
      fac_q    <= '0;
      sq_q     <= 1'b0;
      fp_q     <= 1'b0;
      p_q      <= '0;
      s_q      <= '0;
      q_q      <= '0;
      valid_q  <= 1'b0;
      result_q <= '0;
      rem_q    <= '0;
      g_q      <= 1'b0;
      r_q      <= 1'b0;
      st_q     <= 1'b0;
    end else begin
      if (accept) begin
        lhs_q <= lhs_d;
        fac_q <= fac_d;
        sq_q  <= sq_d;
        fp_q  <= fp_d;
      end
      if (acc_en) begin
        p_q <= p_d;
        s_q <= s_d;
        q_q <= q_d;
      end
      valid_q <= last;
      if (last) begin
        result_q <= res_d;
        rem_q    <= rem_d;
        g_q      <= g_d;
        r_q      <= r_d;
        st_q     <= st_d;
      end
    end
  end

  assign valid      = valid_q;
  assign result     = result_q;
  assign remainder  = rem_q;
  assign res_guard  = g_q;
  assign res_round  = r_q;
  assign res_sticky = st_q;

endmodule

// File: rtl/divroot_checker.sv
module divroot_checker
  import divroot_pkg::*;
#(
  parameter int W = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic [2:0]     op,
  input logic [W-1:0]   opa,
  input logic [W-1:0]   opb,
  input logic           valid,
  input logic [W-1:0]   result,
  input logic [3*W+3:0] remainder,
  input logic           res_guard,
  input logic           res_round,
  input logic           res_sticky
);

  localparam int RW = 3*W + 4;
  localparam int CW = $clog2(W+3) + 1;

  logic [2:0]    c_op;
  logic [W-1:0]  c_a, c_b;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_op <= '0;
      c_a  <= '0;
      c_b  <= '0;
      cnt  <= '0;
    end else if (start && !busy) begin
      c_op <= op;
      c_a  <= opa;
      c_b  <= opb;
      cnt  <= '0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
    end
  end

  logic          c_fp;
  logic [CW-1:0] n_exp;
  logic [RW-1:0] res_w, a_w, b_w, recon;

  assign c_fp  = op_is_fp(c_op);
  assign n_exp = c_fp ? CW'(W+2) : CW'(W);
  assign res_w = {{(RW-W){1'b0}}, result};
  assign a_w   = {{(RW-W){1'b0}}, c_a};
  assign b_w   = {{(RW-W){1'b0}}, c_b};
  assign recon = res_w * b_w + remainder;

  assert_single_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  assert_step_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (cnt == n_exp));

  assert_int_identity_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !c_fp && (c_b != '0)) |-> ((recon == a_w) && (remainder < b_w)));

  assert_zero_divisor_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !c_fp && (c_b == '0)) |-> ((result == '1) && (remainder == a_w)));

  assert_int_no_grs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !c_fp) |-> (!res_guard && !res_round && !res_sticky));

  assert_sticky_exact_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && c_fp) |-> (res_sticky == (remainder != '0)));

  assert_hold_outputs_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> ($stable(result) && $stable(remainder) && $stable(res_sticky)));

endmodule

bind divroot_core divroot_checker #(.W(W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n_s),
  .start      (start),
  .busy       (busy),
  .op         (op),
  .opa        (opa),
  .opb        (opb),
  .valid      (valid),
  .result     (result),
  .remainder  (remainder),
  .res_guard  (res_guard),
  .res_round  (res_round),
  .res_sticky (res_sticky)
);

// File: tb/test_divroot_core.sv
module test_divroot_core;

  localparam int W  = 6;
  localparam int RW = 3*W + 4;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [2:0]    op;
  logic [W-1:0]  opa, opb;
  logic          valid;
  logic [W-1:0]  result;
  logic [RW-1:0] remainder;
  logic          res_guard, res_round, res_sticky;

  divroot_core #(.W(W)) i_divroot_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .op         (op),
    .opa        (opa),
    .opb        (opb),
    .valid      (valid),
    .result     (result),
    .remainder  (remainder),
    .res_guard  (res_guard),
    .res_round  (res_round),
    .res_sticky (res_sticky)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int     n_chk = 0;
  int     n_err = 0;
  longint got_res, got_rem;
  int     got_lat;
  bit     got_g, got_r, got_s, got_pulse;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Integer-arithmetic model of each mode.
  function automatic void ref_calc(input int o, input longint a, input longint b,
                                   output longint q, output longint rem, output bit fp);
    longint lim;
    fp = 1'b1;
    q  = 0;
    case (o)
      1: begin
        lim = a << (W+1);
        q   = lim / b;
        rem = lim - q*b;
      end
      2: begin
        lim = b << (W+3);
        while ((q+1)*(q+1) <= lim) q++;
        rem = lim - q*q;
      end
      3: begin
        lim = longint'(1) << (3*W+1);
        while ((q+1)*(q+1)*b <= lim) q++;
        rem = lim - q*q*b;
      end
      4: begin
        lim = (a*a) << (W+3);
        while ((q+1)*(q+1)*b <= lim) q++;
        rem = lim - q*q*b;
      end
      default: begin
        fp = 1'b0;
        if (b == 0) begin
          q   = (longint'(1) << W) - 1;
          rem = a;
        end else begin
          q   = a / b;
          rem = a % b;
        end
      end
    endcase
  endfunction

  // mode 0: plain; 1: extra start mid-run (R10); 2: inputs changed mid-run (R11)
  task automatic run(input int o, input int a, input int b, input int mode);
    int cnt;
    @(negedge clk);
    op    = 3'(o);
    opa   = W'(a);
    opb   = W'(b);
    start = 1'b1;
    cnt   = 0;
    do begin
      @(negedge clk);
      cnt++;
      if (cnt == 1) start = 1'b0;
      if (mode == 1 && cnt == 3) begin
        start = 1'b1;
        op    = 3'(o ^ 1);
        opa   = ~opa;
        opb   = ~opb;
      end
      if (mode == 1 && cnt == 4) start = 1'b0;
      if (mode == 2 && cnt == 2) begin
        op  = 3'(o ^ 3);
        opa = ~opa;
        opb = ~opb;
      end
    end while (!valid && cnt < 100);
    got_lat = cnt;
    got_res = longint'(result);
    got_rem = longint'(remainder);
    got_g   = res_guard;
    got_r   = res_round;
    got_s   = res_sticky;
    @(negedge clk);
    got_pulse = valid;
  endtask

  task automatic verify(input string req, input int o, input int a, input int b, input int mode);
    longint q, rem;
    bit     fp;
    run(o, a, b, mode);
    ref_calc(o, a, b, q, rem, fp);
    if (fp) begin
      chk(req, "result", got_res, q >> 2);
      chk(req, "remainder", got_rem, rem);
      chk(req, "guard-round", longint'({got_g, got_r}), q & 3);
      chk("R7", "sticky", longint'(got_s), longint'(rem != 0));
      chk("R9", "latency", got_lat, W+3);
    end else begin
      chk(req, "quotient", got_res, q);
      chk(req, "remainder", got_rem, rem);
      chk("R8", "guard-round-sticky", longint'({got_g, got_r, got_s}), 0);
      chk("R9", "latency", got_lat, W+1);
    end
    chk("R9", "valid after pulse", longint'(got_pulse), 0);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++;
    n_err++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    longint held_res, held_rem;
    start = 1'b0;
    op    = '0;
    opa   = '0;
    opb   = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R12: outputs cleared while reset is held
    chk("R12", "valid in reset", longint'(valid), 0);
    chk("R12", "result in reset", longint'(result), 0);
    chk("R12", "remainder in reset", longint'(remainder), 0);
    chk("R12", "flags in reset", longint'({res_guard, res_round, res_sticky}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12", "valid after release", longint'(valid), 0);
    chk("R12", "result after release", longint'(result), 0);

    // R1, R2: every integer operand pair
    for (int a = 0; a < (1 << W); a++) begin
      for (int b = 0; b < (1 << W); b++) begin
        verify((b == 0) ? "R2" : "R1", 0, a, b, 0);
      end
    end
    // R1: spare codes act as integer divide
    for (int c = 5; c < 8; c++) begin
      verify("R1", c, 61, 7, 0);
      verify("R2", c, 19, 0, 0);
    end

    // R3, R6: every normalized pair
    for (int a = (1 << (W-1)); a < (1 << W); a++) begin
      for (int b = (1 << (W-1)); b < (1 << W); b++) begin
        verify("R3", 1, a, b, 0);
        verify("R6", 4, a, b, 0);
      end
    end
    // R4, R5: every normalized operand (includes 1.0 and the largest mantissa)
    for (int b = (1 << (W-1)); b < (1 << W); b++) begin
      verify("R4", 2, 0, b, 0);
      verify("R5", 3, 0, b, 0);
    end

    // R5/R6: reciprocal root of exactly 1.0 is exact, and fused with a=1.0 matches
    run(3, 0, 1 << (W-1), 0);
    chk("R5", "rsqrt(1.0) result", got_res, longint'(1) << (W-1));
    chk("R7", "rsqrt(1.0) sticky", longint'(got_s), 0);
    run(4, 1 << (W-1), 45, 0);
    held_res = got_res;
    held_rem = got_rem;
    run(3, 0, 45, 0);
    chk("R6", "fused a=1.0 result vs rsqrt", held_res, got_res);
    chk("R6", "fused a=1.0 remainder vs rsqrt", held_rem, got_rem);

    // R10: second start during a run is ignored
    verify("R10", 1, 50, 37, 1);
    verify("R10", 0, 55, 6, 1);
    verify("R10", 2, 0, 63, 1);
    // R11: inputs changed after capture have no effect
    verify("R11", 4, 59, 33, 2);
    verify("R11", 0, 40, 3, 2);
    verify("R11", 3, 0, 47, 2);

    // R13: outputs hold while inputs move without start
    verify("R4", 2, 0, 50, 0);
    held_res = got_res;
    held_rem = got_rem;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      op  = 3'(i);
      opa = W'(i * 11);
      opb = W'(i * 5 + 1);
      chk("R13", "held result", longint'(result), held_res);
      chk("R13", "held remainder", longint'(remainder), held_rem);
      chk("R13", "no valid without start", longint'(valid), 0);
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule